// File: doc/BRIEF.md
# Camera Lane Packet Delineator

This block sits behind the deserializer of one camera data lane and turns an unframed byte stream into packets. It waits for a fixed synchronisation byte and then reads a four-byte header: data type, word count low byte, word count high byte, and a check byte. The header is protected by a six-bit single-error-correcting, double-error-detecting code. The block corrects one flipped header bit, and it drops the packet when the code shows a double error.

When the header is accepted, a one-cycle header strobe presents the data type and the word count. Long packets then deliver exactly word-count payload bytes on a byte stream with a valid strobe. The last strobe is asserted together with the final byte. Short packets carry no payload. After each packet the block goes back to searching for sync, so filler between packets is discarded. A frame-active level follows the frame-start and frame-end short packets.

Top module: `cam_pkt_parser`

## Requirements
- R1: While reset is asserted and after it is released, hdr_valid, pay_valid, pay_last and frame_active are low.
- R2: While hunting, any byte other than 0xB8 is discarded, and any byte presented with in_valid low is ignored in every state.
- R3: After sync, the next three valid bytes are the data type, the word count low byte and the word count high byte, in that order. The fourth valid byte is the check byte. hdr_valid pulses for one cycle, registered on the edge that takes the check byte, with hdr_dt and hdr_wc = {high, low}.
- R4: Header data bit i (bits 7:0 data type, 15:8 word count low, 23:16 word count high) has a 6-bit column code. The codes are the i-th values, in ascending order, among the 6-bit values of odd weight 3 or more. Check bit j is the XOR of the data bits whose code has bit j set. Check byte bits 7:6 are ignored. A single flipped data bit is corrected, and a single flipped check bit is tolerated.
- R5: A header whose syndrome is nonzero and is neither a data column code nor of weight one is dropped. There is no hdr_valid and no payload, and the block returns to hunting.
- R6: For an accepted header with data type 0x10 or above (this includes 0x12, embedded data), the next word-count valid bytes appear on pay_data with pay_valid, each registered on the edge that takes it.
- R7: pay_last is high with the final payload byte only.
- R8: A 0xB8 inside a payload is passed on as data. After the last payload byte the block hunts again.
- R9: Data types 0x00 to 0x0F are short packets. Their word count is reported, no payload is consumed, and hunting resumes at once.
- R10: A long packet with word count zero produces the header strobe and no payload.
- R11: frame_active sets on an accepted header with data type 0x00 and clears on one with data type 0x01, in the same cycle as hdr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Deserialized lane byte |
| in_valid | input | 1 | in_byte holds a new byte |
| hdr_valid | output | 1 | One-cycle strobe for an accepted header |
| hdr_dt | output | 8 | Corrected data type |
| hdr_wc | output | 16 | Corrected word count |
| pay_data | output | 8 | Payload byte |
| pay_valid | output | 1 | pay_data is a payload byte |
| pay_last | output | 1 | Final payload byte of the packet |
| frame_active | output | 1 | Between frame start and frame end |

## Verification
The assertions assume that every header or payload output comes from a byte the block took with in_valid high. They also assume that the header and payload strobes never coincide, and that frame_active moves only under the matching header. The stimulus keeps in_valid free of X and uses filler made of bytes other than 0xB8, so sync happens only where the bench intends it. Dropped packets are followed by payload bytes that contain no 0xB8, so no false sync occurs after a drop.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  localparam int HDR_BITS = 24;
  localparam int CHK_BITS = 6;

  typedef enum logic [2:0] {
    ST_HUNT, ST_DT, ST_WCL, ST_WCH, ST_CHK, ST_PAY
  } cpk_state_e;

  // Column code of header data bit idx: idx-th odd-weight (>=3) 6-bit value.
  function automatic logic [CHK_BITS-1:0] cpk_col(input int idx);
    int n;
    logic [CHK_BITS-1:0] res;
    n = 0;
    res = '0;
    for (int v = 0; v < (1 << CHK_BITS); v++) begin
      if ($countones(6'(v)) >= 3 && ($countones(6'(v)) % 2) == 1) begin
        if (n == idx) res = 6'(v);
        n++;
      end
    end
    return res;
  endfunction

  function automatic logic [CHK_BITS-1:0] cpk_parity(input logic [HDR_BITS-1:0] d);
    logic [CHK_BITS-1:0] p;
    p = '0;
    for (int i = 0; i < HDR_BITS; i++)
      if (d[i]) p = p ^ cpk_col(i);
    return p;
  endfunction
endpackage

// File: rtl/cpk_hdr_ecc.sv
module cpk_hdr_ecc
  import cpk_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr_in,
  input  logic [CHK_BITS-1:0] chk_in,
  output logic [HDR_BITS-1:0] hdr_fix,
  output logic                uncorrectable
);
  logic [CHK_BITS-1:0] syndrome;
  logic [HDR_BITS-1:0] hit;

  assign syndrome = cpk_parity(hdr_in) ^ chk_in;

  for (genvar i = 0; i < HDR_BITS; i++) begin : g_col
    localparam logic [CHK_BITS-1:0] COL = cpk_col(i);
    assign hit[i]     = (syndrome == COL);
    assign hdr_fix[i] = hdr_in[i] ^ hit[i];
  end

  assign uncorrectable = (syndrome != '0) && ($countones(syndrome) != 1) && (hit == '0);

  // R4: at most one data bit is ever flipped back
  always_comb begin
    p_one_fix_r4: assert ($onehot0(hit));
  end
endmodule

// File: rtl/cpk_pay_ctr.sv
module cpk_pay_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt;
  logic             busy;

  assign busy    = (cnt != '0);
  assign at_last = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (step && busy) cnt <= cnt - CNT_W'(1);
  end

  // R7: the count empties only by consuming a byte
  p_empty_by_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(step));
endmodule

// File: rtl/cam_pkt_parser.sv
module cam_pkt_parser
  import cpk_pkg::*;
#(
  parameter logic [7:0] SYNC_VAL   = 8'hB8,
  parameter logic [7:0] SHORT_LAST = 8'h0F,
  parameter logic [7:0] FS_DT      = 8'h00,
  parameter logic [7:0] FE_DT      = 8'h01,
  parameter int         WC_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      in_byte,
  input  logic            in_valid,
  output logic            hdr_valid,
  output logic [7:0]      hdr_dt,
  output logic [WC_W-1:0] hdr_wc,
  output logic [7:0]      pay_data,
  output logic            pay_valid,
  output logic            pay_last,
  output logic            frame_active
);
  localparam int HB = 8 + WC_W;

  cpk_state_e      state;
  logic [7:0]      dt_q, wcl_q, wch_q;
  logic [HB-1:0]   hdr_fix;
  logic            hdr_bad;
  logic            hdr_take, hdr_drop, hdr_accept, is_long, pay_take, ctr_last;
  logic [7:0]      fix_dt;
  logic [WC_W-1:0] fix_wc;

  cpk_hdr_ecc u_ecc (
    .hdr_in        ({wch_q, wcl_q, dt_q}),
    .chk_in        (in_byte[CHK_BITS-1:0]),
    .hdr_fix       (hdr_fix),
    .uncorrectable (hdr_bad)
  );

  assign fix_dt     = hdr_fix[7:0];
  assign fix_wc     = hdr_fix[HB-1:8];
  assign hdr_take   = (state == ST_CHK) && in_valid;
  assign hdr_drop   = hdr_take && hdr_bad;
  assign hdr_accept = hdr_take && !hdr_bad;
  assign is_long    = (fix_dt > SHORT_LAST) && (fix_wc != '0);
  assign pay_take   = (state == ST_PAY) && in_valid;

  cpk_pay_ctr #(.CNT_W(WC_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hdr_accept && is_long),
    .load_val (fix_wc),
    .step     (pay_take),
    .at_last  (ctr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_HUNT;
      dt_q         <= '0;
      wcl_q        <= '0;
      wch_q        <= '0;
      hdr_valid    <= 1'b0;
      hdr_dt       <= '0;
      hdr_wc       <= '0;
      pay_data     <= '0;
      pay_valid    <= 1'b0;
      pay_last     <= 1'b0;
      frame_active <= 1'b0;
    end else begin
      hdr_valid <= 1'b0;
      pay_valid <= 1'b0;
      pay_last  <= 1'b0;
      if (in_valid) begin
        unique case (state)
          ST_HUNT: if (in_byte == SYNC_VAL) state <= ST_DT;
          ST_DT:  begin dt_q  <= in_byte; state <= ST_WCL; end
          ST_WCL: begin wcl_q <= in_byte; state <= ST_WCH; end
          ST_WCH: begin wch_q <= in_byte; state <= ST_CHK; end
          ST_CHK: begin
            if (hdr_bad) begin
              state <= ST_HUNT;
            end else begin
              hdr_valid <= 1'b1;
              hdr_dt    <= fix_dt;
              hdr_wc    <= fix_wc;
              if (fix_dt == FS_DT)      frame_active <= 1'b1;
              else if (fix_dt == FE_DT) frame_active <= 1'b0;
              state <= is_long ? ST_PAY : ST_HUNT;
            end
          end
          ST_PAY: begin
            pay_valid <= 1'b1;
            pay_data  <= in_byte;
            pay_last  <= ctr_last;
            if (ctr_last) state <= ST_HUNT;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  p_last_has_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pay_last |-> pay_valid);
  p_pay_from_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> $past(in_valid));
  p_hdr_from_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> $past(in_valid));
  p_hdr_pay_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_valid && pay_valid));
  p_drop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_drop |=> !hdr_valid && !pay_valid);
  p_fs_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> hdr_valid && hdr_dt == FS_DT);
  p_fe_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_active) |-> hdr_valid && hdr_dt == FE_DT);
endmodule

// File: tb/cam_pkt_parser_tb.sv
module cam_pkt_parser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_valid = 1'b0;
  logic        hdr_valid, pay_valid, pay_last, frame_active;
  logic [7:0]  hdr_dt, pay_data;
  logic [15:0] hdr_wc;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cam_pkt_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .hdr_valid(hdr_valid), .hdr_dt(hdr_dt), .hdr_wc(hdr_wc),
    .pay_data(pay_data), .pay_valid(pay_valid), .pay_last(pay_last),
    .frame_active(frame_active)
  );

  // observed events
  int          hdr_seen, pay_seen, last_seen, last_at;
  logic [7:0]  got_dt;
  logic [15:0] got_wc;
  logic [7:0]  got_pay [64];

  always @(negedge clk) begin
    if (hdr_valid) begin hdr_seen++; got_dt = hdr_dt; got_wc = hdr_wc; end
    if (pay_valid) begin
      if (pay_seen < 64) got_pay[pay_seen] = pay_data;
      if (pay_last) begin last_seen++; last_at = pay_seen; end
      pay_seen++;
    end else if (pay_last) last_seen++;
  end

  task automatic clear_obs();
    hdr_seen = 0; pay_seen = 0; last_seen = 0; last_at = -1;
  endtask

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R4 code built from its stated definition
  logic [5:0] code [24];
  initial begin
    int n = 0;
    for (int v = 0; v < 64; v++)
      if (n < 24 && $countones(v[5:0]) >= 3 && $countones(v[5:0]) % 2 == 1) begin
        code[n] = v[5:0]; n++;
      end
  end

  function automatic logic [7:0] chk_of(input logic [23:0] d);
    logic [7:0] e = '0;
    for (int i = 0; i < 24; i++) if (d[i]) e[5:0] = e[5:0] ^ code[i];
    return e;
  endfunction

  task automatic put(input logic [7:0] b);
    in_byte = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'h00;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [7:0] dt, input logic [15:0] wc, input logic [23:0] dflip,
                          input logic [7:0] eflip, input logic [7:0] seed, input int nbytes);
    logic [23:0] d = {wc, dt};
    logic [23:0] tx = d ^ dflip;
    put(8'h00); put(8'hFF); put(8'h47);
    put(8'hB8);
    put(tx[7:0]); put(tx[15:8]); put(tx[23:16]);
    put(chk_of(d) ^ eflip);
    for (int k = 0; k < nbytes; k++) put(seed + 8'(k));
    idle(2);
  endtask

  task automatic judge(input string req, input logic [7:0] dt, input logic [15:0] wc,
                       input bit acc, input logic [7:0] seed);
    int np = (acc && dt > 8'h0F) ? int'(wc) : 0;
    check(req, "hdr count", hdr_seen, acc ? 1 : 0);
    if (acc) begin
      check(req, "dt", got_dt, dt);
      check(req, "wc", got_wc, wc);
    end
    check(req, "payload count", pay_seen, np);
    for (int k = 0; k < np && k < 64; k++) check(req, "payload byte", got_pay[k], seed + 8'(k));
    check(req, "last count", last_seen, np > 0 ? 1 : 0);
    if (np > 0) check(req, "last position", last_at, np - 1);
  endtask

  // {dt, wc, data flips, check flips, accepted}
  localparam int NV = 10;
  localparam logic [56:0] VEC [NV] = '{
    {8'h2A, 16'h0005, 24'h000000, 8'h00, 1'b1},  // R3 R6 clean
    {8'h12, 16'h0003, 24'h000000, 8'h00, 1'b1},  // R6 embedded data
    {8'h2B, 16'h0004, 24'h000001, 8'h00, 1'b1},  // R4 dt bit fixed
    {8'h2A, 16'h0002, 24'h100000, 8'h00, 1'b1},  // R4 wc high bit fixed
    {8'h2A, 16'h0003, 24'h000000, 8'h04, 1'b1},  // R4 check bit flip
    {8'h2A, 16'h0003, 24'h000022, 8'h00, 1'b0},  // R5 double error
    {8'h02, 16'h1234, 24'h000000, 8'h00, 1'b1},  // R9 short
    {8'h2C, 16'h0000, 24'h000000, 8'h00, 1'b1},  // R10 empty long
    {8'h2D, 16'h0002, 24'h000000, 8'hC0, 1'b1},  // R4 top bits ignored
    {8'h2E, 16'h0003, 24'h000008, 8'h01, 1'b0}   // R5 data+check error
  };

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    check("R1", "reset outputs", {hdr_valid, pay_valid, pay_last, frame_active}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release", {hdr_valid, pay_valid, pay_last, frame_active}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0]  dt   = VEC[v][56:49];
      logic [15:0] wc   = VEC[v][48:33];
      logic [23:0] df   = VEC[v][32:9];
      logic [7:0]  ef   = VEC[v][8:1];
      bit          acc  = VEC[v][0];
      logic [7:0]  seed = 8'h20 + 8'(v * 16);
      int nb = (dt > 8'h0F || !acc) ? int'(wc) : 0;
      clear_obs();
      send_pkt(dt, wc, df, ef, seed, nb);
      judge("R3/R4/R5/R6", dt, wc, acc, seed);
    end

    // R8: sync value inside payload is data, then hunting resumes
    clear_obs();
    send_pkt(8'h2A, 16'd20, 24'h0, 8'h00, 8'hB0, 20);
    judge("R8", 8'h2A, 16'd20, 1'b1, 8'hB0);
    clear_obs();
    put(8'h33); put(8'h01); put(8'h00); put(8'h44); idle(2);
    check("R8", "filler after packet", hdr_seen + pay_seen, 0);

    // R2: sync held with in_valid low is ignored
    clear_obs();
    in_byte = 8'hB8; in_valid = 1'b0;
    repeat (5) @(negedge clk);
    put(8'h2A); put(8'h01); put(8'h00); put(chk_of({16'h0001, 8'h2A})); put(8'h55); idle(2);
    check("R2", "no sync without valid", hdr_seen + pay_seen, 0);

    // R2 R7: bubbles inside a packet
    clear_obs();
    put(8'hB8); idle(2); put(8'h2F); idle(1); put(8'h02); put(8'h00);
    idle(3); put(chk_of({16'h0002, 8'h2F}));
    idle(2); put(8'h61); idle(4);
    check("R7", "no last before final", last_seen, 0);
    put(8'h62); idle(2);
    judge("R2", 8'h2F, 16'h0002, 1'b1, 8'h61);

    // R11 frame activity
    clear_obs();
    send_pkt(8'h00, 16'h0007, 24'h0, 8'h00, 8'h00, 0);
    check("R11", "frame start", frame_active, 1);
    send_pkt(8'h2A, 16'h0001, 24'h0, 8'h00, 8'h10, 1);
    check("R11", "hold during line", frame_active, 1);
    send_pkt(8'h01, 16'h0007, 24'h0, 8'h00, 8'h00, 0);
    check("R11", "frame end", frame_active, 0);

    // R1 mid-run reset clears frame activity
    send_pkt(8'h00, 16'h0000, 24'h0, 8'h00, 8'h00, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reset mid frame", frame_active, 0);
    rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule